// File: doc/BRIEF.md
# Field-Attributed AXI4-Lite Register Bank

This block is an AXI4-Lite slave holding four 32-bit registers. The registers are built from fields, and each field carries its own attributes. Software access can be read, write or both. Hardware access can be read, write or both. A field may also have a reset value and a software-write strobe. A hardware-readable field drives an output port. A hardware-writable field reloads from an input port on every clock. The field table is a constant in the package, and one field slice is generated for each entry.

On the write channel, the address and the data may arrive in either order or together. The write reaches the register exactly once, on the first cycle of the response. On the read channel, each accepted address yields one beat of read data. That data is assembled only from the fields that software may read. Byte-strobe masking, protection and error responses are not part of the block. Both responses are always OKAY.

Top module: `axil_field_regbank`

## Requirements
- R1: The register map is addressed by word index (byte address bits [ADDR_W-1:2]) and is laid out as follows.
  - Word 0, bits [7:0], ctl_lo: software read/write, hardware read, reset 0x5A, strobe.
  - Word 0, bits [15:8], ctl_hi: software read/write, hardware read, reset 0x00.
  - Word 1, bits [15:0], sts: software read only, hardware write, no reset.
  - Word 2, bits [3:0], mix_val: software read/write, hardware read and write, reset 0x3, strobe.
  - Word 2, bits [31:24], mix_key: software write only, hardware read, reset 0xC3.
  - Word 3, bits [31:0], scratch: software read/write, reset 0.
  While reset is applied, awready, wready and arready are high and bvalid and rvalid are low.
- R2: A write completes whether the address comes first, the data comes first, or both come in the same cycle. awready is high only when idle or when waiting for the address. wready is high only when idle or when waiting for the data.
- R3: bvalid rises in the cycle after the second of address and data has been accepted. It stays high until bready is sampled. While bvalid is high, no new address or data is accepted. Each write updates its register once.
- R4: arready is high only while no read beat is pending. rvalid rises in the cycle after arvalid is accepted. rvalid and rdata hold steady until rready is sampled.
- R5: The two low address bits are ignored on both channels.
- R6: Read data contains only software-readable fields. All other bits read 0, including the write-only mix_key.
- R7: bresp and rresp are always 2'b00.
- R8: A write to word 0 or word 2 pulses that register's strobe output (ctl_lo_mod_o, mix_val_mod_o) high for exactly one cycle, one cycle after bvalid rises. A write to any other word pulses no strobe.
- R9: sts reloads from sts_val_i on every clock. Software writes to sts are ignored.
- R10: When hardware and software both update mix_val, the hardware input wins. mix_val_o equals mix_val_i as sampled at the previous clock edge.
- R11: A read of an unmapped word returns 0 with OKAY. A write to an unmapped word is acknowledged, changes no field, and pulses no strobe.
- R12: Each hardware-readable output shows the current content of its field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| awaddr_i | input | ADDR_W | Write byte address |
| awvalid_i | input | 1 | Write address valid |
| awready_o | output | 1 | Write address ready |
| wdata_i | input | 32 | Write data |
| wvalid_i | input | 1 | Write data valid |
| wready_o | output | 1 | Write data ready |
| bresp_o | output | 2 | Write response, always OKAY |
| bvalid_o | output | 1 | Write response valid |
| bready_i | input | 1 | Write response ready |
| araddr_i | input | ADDR_W | Read byte address |
| arvalid_i | input | 1 | Read address valid |
| arready_o | output | 1 | Read address ready |
| rdata_o | output | 32 | Read data |
| rresp_o | output | 2 | Read response, always OKAY |
| rvalid_o | output | 1 | Read data valid |
| rready_i | input | 1 | Read data ready |
| ctl_lo_o | output | 8 | ctl_lo field content |
| ctl_lo_mod_o | output | 1 | Strobe on a software write to word 0 |
| ctl_hi_o | output | 8 | ctl_hi field content |
| sts_val_i | input | 16 | Hardware source for sts |
| mix_val_i | input | 4 | Hardware source for mix_val |
| mix_val_o | output | 4 | mix_val field content |
| mix_val_mod_o | output | 1 | Strobe on a software write to word 2 |
| mix_key_o | output | 8 | mix_key field content |

## Verification
The bench uses the default ADDR_W of 8. That gives 64 word slots, of which only four are mapped, so random byte addresses in the first 32 bytes land on mapped words, on unmapped words and on unaligned offsets. The fixed field table covers every access combination in use. This includes a field that is both hardware- and software-writable, where the priority can be observed, and a write-only field that must read as zero while its output changes.

// File: rtl/axil_fregs_pkg.sv
package axil_fregs_pkg;

  localparam int DATA_W     = 32;
  localparam int NUM_REGS   = 4;
  localparam int NUM_FIELDS = 6;

  localparam int R_CTL = 0;
  localparam int R_STS = 1;
  localparam int R_MIX = 2;
  localparam int R_SCR = 3;

  localparam int F_CTL_LO  = 0;
  localparam int F_CTL_HI  = 1;
  localparam int F_STS     = 2;
  localparam int F_MIX_VAL = 3;
  localparam int F_MIX_KEY = 4;
  localparam int F_SCRATCH = 5;

  typedef struct packed {
    logic [7:0]  reg_idx;
    logic [7:0]  msb;
    logic [7:0]  lsb;
    logic        sw_rd;
    logic        sw_wr;
    logic        hw_rd;
    logic        hw_wr;
    logic        has_rst;
    logic        strobe;
    logic [31:0] rst_val;
  } field_t;

  //                      reg    msb    lsb   swr   sww   hwr   hww   rst   stb   reset value
  localparam field_t FIELD_MAP [NUM_FIELDS] = '{
    '{8'd0, 8'd7,  8'd0,  1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 32'h5A},
    '{8'd0, 8'd15, 8'd8,  1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 32'h00},
    '{8'd1, 8'd15, 8'd0,  1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 32'h00},
    '{8'd2, 8'd3,  8'd0,  1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 32'h3},
    '{8'd2, 8'd31, 8'd24, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 32'hC3},
    '{8'd3, 8'd31, 8'd0,  1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 32'h0}
  };

  function automatic logic [NUM_REGS-1:0] strobe_regs();
    logic [NUM_REGS-1:0] m;
    m = '0;
    for (int f = 0; f < NUM_FIELDS; f++)
      if (FIELD_MAP[f].strobe) m[int'(FIELD_MAP[f].reg_idx)] = 1'b1;
    return m;
  endfunction

  typedef enum logic [1:0] {
    WR_IDLE      = 2'd0,
    WR_WAIT_DATA = 2'd1,
    WR_WAIT_ADDR = 2'd2,
    WR_RESP      = 2'd3
  } wr_state_e;

  typedef enum logic {
    RD_IDLE  = 1'b0,
    RD_VALID = 1'b1
  } rd_state_e;

endpackage

// File: rtl/axil_fregs_field.sv
module axil_fregs_field #(
  parameter int unsigned    W       = 8,
  parameter bit             SW_WR   = 1'b1,
  parameter bit             HW_WR   = 1'b0,
  parameter bit             HAS_RST = 1'b1,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         sw_we_i,
  input  logic [W-1:0] sw_data_i,
  input  logic [W-1:0] hw_data_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] q;
  logic [W-1:0] nxt;

  always_comb begin
    nxt = q;
    if (SW_WR && sw_we_i) nxt = sw_data_i;
    if (HW_WR) nxt = hw_data_i;  // hardware overrides software
  end

  if (HAS_RST) begin : g_rst
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q <= RST_VAL;
      else         q <= nxt;
    end
  end else begin : g_norst
    always_ff @(posedge clk_i) q <= nxt;
  end

  assign q_o = q;

  logic unused_in;
  assign unused_in = ^{hw_data_i, sw_data_i, sw_we_i, rst_ni};

endmodule

// File: rtl/axil_fregs_wr.sv
module axil_fregs_wr
  import axil_fregs_pkg::*;
#(
  parameter int AW = 6,
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] aw_word_i,
  input  logic          awvalid_i,
  output logic          awready_o,
  input  logic [DW-1:0] wdata_i,
  input  logic          wvalid_i,
  output logic          wready_o,
  output logic          bvalid_o,
  input  logic          bready_i,
  output logic [AW-1:0] waddr_o,
  output logic [DW-1:0] wdata_o,
  output logic          commit_o
);

  wr_state_e     st, st_prev, st_nxt;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;

  always_comb begin
    st_nxt = st;
    case (st)
      WR_IDLE: begin
        if (awvalid_i && wvalid_i) st_nxt = WR_RESP;
        else if (awvalid_i)        st_nxt = WR_WAIT_DATA;
        else if (wvalid_i)         st_nxt = WR_WAIT_ADDR;
      end
      WR_WAIT_DATA: if (wvalid_i)  st_nxt = WR_RESP;
      WR_WAIT_ADDR: if (awvalid_i) st_nxt = WR_RESP;
      WR_RESP:      if (bready_i)  st_nxt = WR_IDLE;
      default:                     st_nxt = WR_IDLE;
    endcase
  end

  assign awready_o = (st == WR_IDLE) || (st == WR_WAIT_ADDR);
  assign wready_o  = (st == WR_IDLE) || (st == WR_WAIT_DATA);
  assign bvalid_o  = (st == WR_RESP);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st      <= WR_IDLE;
      st_prev <= WR_IDLE;
      addr_q  <= '0;
      data_q  <= '0;
    end else begin
      st      <= st_nxt;
      st_prev <= st;
      if (awvalid_i && awready_o) addr_q <= aw_word_i;
      if (wvalid_i && wready_o)   data_q <= wdata_i;
    end
  end

  // single commit: first cycle of the response state
  assign commit_o = (st == WR_RESP) && (st_prev != WR_RESP);
  assign waddr_o  = addr_q;
  assign wdata_o  = data_q;

endmodule

// File: rtl/axil_fregs_rd.sv
module axil_fregs_rd
  import axil_fregs_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          arvalid_i,
  output logic          arready_o,
  input  logic [DW-1:0] rd_word_i,
  output logic [DW-1:0] rdata_o,
  output logic          rvalid_o,
  input  logic          rready_i
);

  rd_state_e     st;
  logic [DW-1:0] rdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st      <= RD_IDLE;
      rdata_q <= '0;
    end else begin
      case (st)
        RD_IDLE: if (arvalid_i) begin
          st      <= RD_VALID;
          rdata_q <= rd_word_i;
        end
        RD_VALID: if (rready_i) st <= RD_IDLE;
        default:  st <= RD_IDLE;
      endcase
    end
  end

  assign arready_o = (st == RD_IDLE);
  assign rvalid_o  = (st == RD_VALID);
  assign rdata_o   = rdata_q;

endmodule

// File: rtl/axil_field_regbank.sv
module axil_field_regbank
  import axil_fregs_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] awaddr_i,
  input  logic              awvalid_i,
  output logic              awready_o,
  input  logic [31:0]       wdata_i,
  input  logic              wvalid_i,
  output logic              wready_o,
  output logic [1:0]        bresp_o,
  output logic              bvalid_o,
  input  logic              bready_i,
  input  logic [ADDR_W-1:0] araddr_i,
  input  logic              arvalid_i,
  output logic              arready_o,
  output logic [31:0]       rdata_o,
  output logic [1:0]        rresp_o,
  output logic              rvalid_o,
  input  logic              rready_i,
  output logic [7:0]        ctl_lo_o,
  output logic              ctl_lo_mod_o,
  output logic [7:0]        ctl_hi_o,
  input  logic [15:0]       sts_val_i,
  input  logic [3:0]        mix_val_i,
  output logic [3:0]        mix_val_o,
  output logic              mix_val_mod_o,
  output logic [7:0]        mix_key_o
);

  localparam int WORD_W = ADDR_W - 2;
  localparam logic [NUM_REGS-1:0] STROBE_REGS = strobe_regs();

  logic [WORD_W-1:0] aw_word;
  logic [DATA_W-1:0] wdata_q;
  logic              commit;
  logic [DATA_W-1:0] rd_word;

  logic [NUM_FIELDS-1:0][DATA_W-1:0] hw_feed;
  logic [NUM_FIELDS-1:0][DATA_W-1:0] fld_pos;
  logic [NUM_REGS-1:0]               mod_q;

  axil_fregs_wr #(.AW(WORD_W), .DW(DATA_W)) u_wr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .aw_word_i (awaddr_i[ADDR_W-1:2]),
    .awvalid_i (awvalid_i),
    .awready_o (awready_o),
    .wdata_i   (wdata_i),
    .wvalid_i  (wvalid_i),
    .wready_o  (wready_o),
    .bvalid_o  (bvalid_o),
    .bready_i  (bready_i),
    .waddr_o   (aw_word),
    .wdata_o   (wdata_q),
    .commit_o  (commit)
  );

  axil_fregs_rd #(.DW(DATA_W)) u_rd (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .arvalid_i (arvalid_i),
    .arready_o (arready_o),
    .rd_word_i (rd_word),
    .rdata_o   (rdata_o),
    .rvalid_o  (rvalid_o),
    .rready_i  (rready_i)
  );

  always_comb begin
    hw_feed            = '0;
    hw_feed[F_STS]     = DATA_W'(sts_val_i);
    hw_feed[F_MIX_VAL] = DATA_W'(mix_val_i);
  end

  for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_fld
    localparam int MSB = int'(FIELD_MAP[i].msb);
    localparam int LSB = int'(FIELD_MAP[i].lsb);
    localparam int W   = MSB - LSB + 1;
    logic [W-1:0] q;
    logic         we;

    assign we = commit && (int'(aw_word) == int'(FIELD_MAP[i].reg_idx));

    axil_fregs_field #(
      .W       (W),
      .SW_WR   (FIELD_MAP[i].sw_wr),
      .HW_WR   (FIELD_MAP[i].hw_wr),
      .HAS_RST (FIELD_MAP[i].has_rst),
      .RST_VAL (FIELD_MAP[i].rst_val[W-1:0])
    ) u_field (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .sw_we_i   (we),
      .sw_data_i (wdata_q[MSB:LSB]),
      .hw_data_i (hw_feed[i][W-1:0]),
      .q_o       (q)
    );

    assign fld_pos[i] = DATA_W'(q) << LSB;
  end

  // read word: software-readable fields of the addressed register only
  always_comb begin
    rd_word = '0;
    for (int f = 0; f < NUM_FIELDS; f++)
      if (FIELD_MAP[f].sw_rd &&
          (int'(araddr_i[ADDR_W-1:2]) == int'(FIELD_MAP[f].reg_idx)))
        rd_word = rd_word | fld_pos[f];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mod_q <= '0;
    else
      for (int r = 0; r < NUM_REGS; r++)
        mod_q[r] <= commit && (int'(aw_word) == r) && STROBE_REGS[r];
  end

  assign bresp_o       = 2'b00;
  assign rresp_o       = 2'b00;
  assign ctl_lo_o      = fld_pos[F_CTL_LO][7:0];
  assign ctl_hi_o      = fld_pos[F_CTL_HI][15:8];
  assign mix_val_o     = fld_pos[F_MIX_VAL][3:0];
  assign mix_key_o     = fld_pos[F_MIX_KEY][31:24];
  assign ctl_lo_mod_o  = mod_q[R_CTL];
  assign mix_val_mod_o = mod_q[R_MIX];

  logic unused_bits;
  assign unused_bits = ^{awaddr_i[1:0], araddr_i[1:0], hw_feed, mod_q};

endmodule

// File: rtl/axil_field_regbank_chk.sv
module axil_field_regbank_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        awready_o,
  input logic        wready_o,
  input logic        bvalid_o,
  input logic        bready_i,
  input logic        arready_o,
  input logic        rvalid_o,
  input logic        rready_i,
  input logic [31:0] rdata_o,
  input logic        ctl_lo_mod_o,
  input logic        mix_val_mod_o,
  input logic [3:0]  mix_val_i,
  input logic [3:0]  mix_val_o
);

  logic armed;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed <= 1'b0;
    else         armed <= 1'b1;
  end

  AST_RESP_NO_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bvalid_o |-> (!awready_o && !wready_o));  // R2

  AST_BVALID_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bvalid_o && !bready_i) |=> bvalid_o);  // R3

  AST_RVALID_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rvalid_o && !rready_i) |=> (rvalid_o && $stable(rdata_o)));  // R4

  AST_AR_BLOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |-> !arready_o);  // R4

  AST_CTL_STROBE_WIDTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_lo_mod_o |=> !ctl_lo_mod_o);  // R8

  AST_MIX_STROBE_WIDTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mix_val_mod_o |=> !mix_val_mod_o);  // R8

  AST_STROBE_AFTER_RESP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_lo_mod_o || mix_val_mod_o) |-> $past(bvalid_o));  // R8

  AST_STROBE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ctl_lo_mod_o && mix_val_mod_o));  // R8

  AST_HW_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed |-> (mix_val_o == $past(mix_val_i)));  // R10

endmodule

bind axil_field_regbank axil_field_regbank_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .awready_o     (awready_o),
  .wready_o      (wready_o),
  .bvalid_o      (bvalid_o),
  .bready_i      (bready_i),
  .arready_o     (arready_o),
  .rvalid_o      (rvalid_o),
  .rready_i      (rready_i),
  .rdata_o       (rdata_o),
  .ctl_lo_mod_o  (ctl_lo_mod_o),
  .mix_val_mod_o (mix_val_mod_o),
  .mix_val_i     (mix_val_i),
  .mix_val_o     (mix_val_o)
);

// File: tb/axil_field_regbank_tb_top.sv
module axil_field_regbank_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 8;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic [ADDR_W-1:0] awaddr_i = '0;
  logic              awvalid_i = 1'b0;
  logic              awready_o;
  logic [31:0]       wdata_i = '0;
  logic              wvalid_i = 1'b0;
  logic              wready_o;
  logic [1:0]        bresp_o;
  logic              bvalid_o;
  logic              bready_i = 1'b0;
  logic [ADDR_W-1:0] araddr_i = '0;
  logic              arvalid_i = 1'b0;
  logic              arready_o;
  logic [31:0]       rdata_o;
  logic [1:0]        rresp_o;
  logic              rvalid_o;
  logic              rready_i = 1'b0;
  logic [7:0]        ctl_lo_o;
  logic              ctl_lo_mod_o;
  logic [7:0]        ctl_hi_o;
  logic [15:0]       sts_val_i = 16'h0000;
  logic [3:0]        mix_val_i = 4'h0;
  logic [3:0]        mix_val_o;
  logic              mix_val_mod_o;
  logic [7:0]        mix_key_o;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  axil_field_regbank #(.ADDR_W(ADDR_W)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .awaddr_i(awaddr_i), .awvalid_i(awvalid_i), .awready_o(awready_o),
    .wdata_i(wdata_i), .wvalid_i(wvalid_i), .wready_o(wready_o),
    .bresp_o(bresp_o), .bvalid_o(bvalid_o), .bready_i(bready_i),
    .araddr_i(araddr_i), .arvalid_i(arvalid_i), .arready_o(arready_o),
    .rdata_o(rdata_o), .rresp_o(rresp_o), .rvalid_o(rvalid_o), .rready_i(rready_i),
    .ctl_lo_o(ctl_lo_o), .ctl_lo_mod_o(ctl_lo_mod_o), .ctl_hi_o(ctl_hi_o),
    .sts_val_i(sts_val_i), .mix_val_i(mix_val_i), .mix_val_o(mix_val_o),
    .mix_val_mod_o(mix_val_mod_o), .mix_key_o(mix_key_o)
  );

  int checks = 0;
  int errors = 0;

  // bench model of the software-visible fields
  logic [7:0]  m_lo  = 8'h5A;
  logic [7:0]  m_hi  = 8'h00;
  logic [7:0]  m_key = 8'hC3;
  logic [31:0] m_scr = 32'h0;

  // strobe monitor, sampled 2 time units after each rising edge
  int cyc = 0, bv_rise = -10, lo_cnt = 0, mix_cnt = 0, last_stb = -10;
  int run = 0, max_run = 0;
  logic bv_prev = 1'b0;
  always @(posedge clk_i) begin
    #2;
    cyc++;
    if (bvalid_o && !bv_prev) bv_rise = cyc;
    bv_prev = bvalid_o;
    if (ctl_lo_mod_o)  begin lo_cnt++;  last_stb = cyc; end
    if (mix_val_mod_o) begin mix_cnt++; last_stb = cyc; end
    if (ctl_lo_mod_o || mix_val_mod_o) run++; else run = 0;
    if (run > max_run) max_run = run;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_rd(input int word);
    case (word)
      0:       return {16'h0, m_hi, m_lo};
      1:       return {16'h0, sts_val_i};
      2:       return {28'h0, mix_val_i};   // mix_key is write-only
      3:       return m_scr;
      default: return 32'h0;
    endcase
  endfunction

  task automatic model_wr(input int word, input logic [31:0] d);
    case (word)
      0: begin m_lo = d[7:0]; m_hi = d[15:8]; end
      2: m_key = d[31:24];
      3: m_scr = d;
      default: ;
    endcase
  endtask

  // mode 0: together, 1: address first, 2: data first
  task automatic do_write(input logic [ADDR_W-1:0] addr, input logic [31:0] data,
                          input int mode, input int gap, input int bdly);
    int word;
    int lo0, mx0;
    word = int'(addr >> 2);
    lo0 = lo_cnt; mx0 = mix_cnt;
    chk(awready_o && wready_o, "R2 idle ready", {30'h0, awready_o, wready_o}, 32'h3);
    if (mode == 0) begin
      awaddr_i = addr; wdata_i = data; awvalid_i = 1'b1; wvalid_i = 1'b1;
      @(posedge clk_i); @(negedge clk_i);
      awvalid_i = 1'b0; wvalid_i = 1'b0;
    end else if (mode == 1) begin
      awaddr_i = addr; awvalid_i = 1'b1;
      @(posedge clk_i); @(negedge clk_i);
      awvalid_i = 1'b0;
      chk(!awready_o && wready_o && !bvalid_o, "R2 waiting for data",
          {29'h0, awready_o, wready_o, bvalid_o}, 32'h2);
      repeat (gap) @(negedge clk_i);
      wdata_i = data; wvalid_i = 1'b1;
      @(posedge clk_i); @(negedge clk_i);
      wvalid_i = 1'b0;
    end else begin
      wdata_i = data; wvalid_i = 1'b1;
      @(posedge clk_i); @(negedge clk_i);
      wvalid_i = 1'b0;
      chk(awready_o && !wready_o && !bvalid_o, "R2 waiting for address",
          {29'h0, awready_o, wready_o, bvalid_o}, 32'h4);
      repeat (gap) @(negedge clk_i);
      awaddr_i = addr; awvalid_i = 1'b1;
      @(posedge clk_i); @(negedge clk_i);
      awvalid_i = 1'b0;
    end
    chk(bvalid_o && !awready_o && !wready_o, "R3 response raised",
        {29'h0, bvalid_o, awready_o, wready_o}, 32'h4);
    chk(bresp_o == 2'b00, "R7 bresp", {30'h0, bresp_o}, 32'h0);
    for (int i = 0; i < bdly; i++) begin
      @(negedge clk_i);
      chk(bvalid_o, "R3 bvalid held under back-pressure", {31'h0, bvalid_o}, 32'h1);
    end
    bready_i = 1'b1;
    @(posedge clk_i); @(negedge clk_i);
    bready_i = 1'b0;
    chk(!bvalid_o && awready_o && wready_o, "R3 response released",
        {29'h0, bvalid_o, awready_o, wready_o}, 32'h3);
    model_wr(word, data);
    if (word == 0 || word == 2) begin
      chk((lo_cnt - lo0) == (word == 0 ? 1 : 0) && (mix_cnt - mx0) == (word == 2 ? 1 : 0),
          "R8 strobe count", 32'(lo_cnt - lo0 + 16 * (mix_cnt - mx0)), (word == 0) ? 32'h1 : 32'h10);
      chk(last_stb == bv_rise + 1, "R8 strobe cycle", 32'(last_stb - bv_rise), 32'h1);
    end else begin
      chk(lo_cnt == lo0 && mix_cnt == mx0, "R8 R11 no strobe",
          32'(lo_cnt - lo0 + mix_cnt - mx0), 32'h0);
    end
    chk(ctl_lo_o == m_lo && ctl_hi_o == m_hi, "R12 ctl outputs", {16'h0, ctl_hi_o, ctl_lo_o}, {16'h0, m_hi, m_lo});
    chk(mix_key_o == m_key, "R12 mix_key output", {24'h0, mix_key_o}, {24'h0, m_key});
    chk(mix_val_o == mix_val_i, "R10 hardware value kept", {28'h0, mix_val_o}, {28'h0, mix_val_i});
  endtask

  task automatic do_read(input logic [ADDR_W-1:0] addr, input int rdly, input string req);
    logic [31:0] exp, first;
    exp = exp_rd(int'(addr >> 2));
    chk(arready_o && !rvalid_o, "R4 read idle", {30'h0, arready_o, rvalid_o}, 32'h2);
    araddr_i = addr; arvalid_i = 1'b1;
    @(posedge clk_i); @(negedge clk_i);
    arvalid_i = 1'b0;
    chk(rvalid_o && !arready_o, "R4 rvalid raised", {30'h0, arready_o, rvalid_o}, 32'h1);
    chk(rresp_o == 2'b00, "R7 rresp", {30'h0, rresp_o}, 32'h0);
    chk(rdata_o == exp, req, rdata_o, exp);
    first = rdata_o;
    for (int i = 0; i < rdly; i++) begin
      @(negedge clk_i);
      chk(rvalid_o && rdata_o == first, "R4 beat held under back-pressure", rdata_o, first);
    end
    rready_i = 1'b1;
    @(posedge clk_i); @(negedge clk_i);
    rready_i = 1'b0;
    chk(!rvalid_o && arready_o, "R4 beat released", {30'h0, arready_o, rvalid_o}, 32'h2);
  endtask

  task automatic summary();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=completion");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk(awready_o && wready_o && arready_o && !bvalid_o && !rvalid_o, "R1 handshake reset",
        {27'h0, awready_o, wready_o, arready_o, bvalid_o, rvalid_o}, 32'h1C);
    chk(ctl_lo_o == 8'h5A && ctl_hi_o == 8'h00, "R1 ctl reset", {16'h0, ctl_hi_o, ctl_lo_o}, 32'h5A);
    chk(mix_key_o == 8'hC3, "R1 mix_key reset", {24'h0, mix_key_o}, 32'hC3);
    chk(mix_val_o == 4'h3, "R1 mix_val reset", {28'h0, mix_val_o}, 32'h3);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);

    do_read(8'h00, 0, "R1 R6 ctl word after reset");
    do_read(8'h0C, 1, "R1 scratch after reset");

    do_write(8'h0C, 32'hDEADBEEF, 0, 0, 2);
    do_read(8'h0C, 0, "R2 simultaneous write to scratch");
    do_write(8'h00, 32'h1234A5C3, 1, 2, 0);
    do_read(8'h00, 2, "R2 R6 address-first write, upper bits zero");

    mix_val_i = 4'h6;
    repeat (2) @(negedge clk_i);
    do_write(8'h08, 32'hAB00000F, 2, 1, 1);
    do_read(8'h08, 0, "R10 R6 hardware wins, write-only reads zero");
    chk(mix_key_o == 8'hAB, "R6 mix_key written", {24'h0, mix_key_o}, 32'hAB);

    sts_val_i = 16'h1357;
    repeat (2) @(negedge clk_i);
    do_write(8'h04, 32'hFFFFFFFF, 0, 0, 0);
    do_read(8'h04, 0, "R9 sts ignores software write");
    sts_val_i = 16'hBEEF;
    repeat (2) @(negedge clk_i);
    do_read(8'h04, 0, "R9 sts follows input");

    do_write(8'h40, 32'h0F0F0F0F, 1, 0, 1);
    do_read(8'h00, 0, "R11 ctl unchanged after unmapped write");
    do_read(8'h08, 0, "R11 mix unchanged after unmapped write");
    do_read(8'h0C, 0, "R11 scratch unchanged after unmapped write");
    do_read(8'h44, 1, "R11 unmapped read is zero");

    do_write(8'h0F, 32'h0BADF00D, 0, 0, 0);
    do_read(8'h0C, 0, "R5 unaligned write address");
    do_read(8'h0E, 0, "R5 unaligned read address");

    void'($urandom(32'h5EED));
    for (int n = 0; n < 120; n++) begin
      int kind;
      kind = int'($urandom_range(0, 9));
      if (kind < 2) begin
        sts_val_i = 16'($urandom_range(0, 16'hFFFF));
        mix_val_i = 4'($urandom_range(0, 15));
        repeat (2) @(negedge clk_i);
        chk(mix_val_o == mix_val_i, "R10 mix_val follows input", {28'h0, mix_val_o}, {28'h0, mix_val_i});
      end else if (kind < 6) begin
        do_write(8'($urandom_range(0, 31)), $urandom(), int'($urandom_range(0, 2)),
                 int'($urandom_range(0, 2)), int'($urandom_range(0, 3)));
      end else begin
        do_read(8'($urandom_range(0, 31)), int'($urandom_range(0, 3)), "R6 random read");
      end
    end

    chk(max_run == 1, "R8 strobe pulse width", 32'(max_run), 32'h1);
    summary();
    $finish;
  end

endmodule